// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block holds the digital state behind a bank of up to four voltage-output DAC channels. Each channel owns two registers: a staging (input) register that software fills, and an output register whose code drives the converter. Fully assembled 24-bit command words arrive from a serial receiver with a one-cycle valid strobe. The upper byte is the opcode and the lower sixteen bits carry data. The block decodes each word and performs staged writes, immediate writes, masked transfers from staging to output, a software clear, per-channel power-down, a READY-enable bit and a linearity-calibration bit.

An active-low hardware load pin moves every staging register into its output register. While that pin is held low, staged writes reach the outputs directly. A mode pin picks the output code that reset and clear restore: zero or midscale. The code width (16 or 12 bits) and the channel count (2 or 4) are parameters. In the 12-bit build the four low data bits are ignored. The shared reference is reported as powered down only when every channel that exists is off.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After reset every staging register is zero and every output code is zero when `midscale_sel` is 0, or midscale (only the top code bit set) when it is 1. All channels are powered up, `ready_en` is 1, and `lin_cal` and `ref_off` are 0.
- R2: Opcode 0x1m (word bits 23..20 = 1) writes the data into the staging register of each channel i whose bit i in m (word bits 19..16) is set. No output code changes. The result shows once a later transfer moves the staging value to the output.
- R3: Opcode 0x3m writes the data into both registers of each flagged channel. The output code is visible on the clock edge that accepts the command.
- R4: Opcode 0x01 copies the staging register into the output register for each channel i whose bit 8+i of the word is set. Unflagged outputs keep their codes.
- R5: Opcode 0x02 restores the whole R1 state, using the value of `midscale_sel` at that moment.
- R6: Opcode 0x03 sets `chan_off[i]` to word bit 8+i for every channel and sets `ready_en` to word bit 7. Output codes are kept across power-down and power-up.
- R7: `ref_off` is 1 exactly when every existing channel is powered down.
- R8: Opcode 0x05 sets `lin_cal` to word bit 8.
- R9: Opcode 0x00, every undefined opcode (0x04, 0x06 to 0x0F, 0x2m, 0x40 and above) and any word presented with `cmd_valid` low leave all state unchanged.
- R10: `load_n` passes through a two-stage synchronizer. Its low level copies every staging register into its output register on the third rising edge after it falls. While it stays low, a write made with opcode 0x1m reaches the output one cycle after the command.
- R11: With a 12-bit code the staging value is word bits 15..4 and bits 3..0 are ignored. Midscale is 0x800. With two channels, mask bits for channels 2 and 3 have no effect, and `ref_off` follows channels 0 and 1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | The command word is valid this cycle |
| cmd_word | input | 24 | Opcode in bits 23..16, data in bits 15..0 |
| load_n | input | 1 | Asynchronous active-low hardware load |
| midscale_sel | input | 1 | Reset/clear code select: 0 = zero, 1 = midscale |
| dac_code | output | NUM_CH*CODE_W | Output codes, channel i at bits i*CODE_W upward |
| chan_off | output | NUM_CH | Per-channel power-down flags |
| ready_en | output | 1 | READY output enable |
| lin_cal | output | 1 | Linearity-calibration bit |
| ref_off | output | 1 | Shared reference powered down |

## Verification
Every command result (staging, output code, power flags, READY-enable, calibration bit, reference flag) is due on the first rising edge after the strobed word. The bench drives the word on a falling edge and compares on the next falling edge. A hardware load settles on the third edge after `load_n` falls. The bench therefore checks that the outputs are unchanged at the first and second falling edges and copied at the third. After release it idles three cycles before the next staged write, so that no late copy is mistaken for a write. A 4-channel 16-bit unit and a 2-channel 12-bit unit share the stimulus, and the bench computes the expected values for both.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int WORD_W    = 24;
    localparam int DATA_W    = 16;
    localparam int MASK_W    = 4;
    localparam int MASK_LO   = 8;
    localparam int BIT_READY = 7;
    localparam int BIT_LIN   = 8;

    localparam logic [3:0] GRP_MISC  = 4'h0;
    localparam logic [3:0] GRP_WRITE = 4'h1;
    localparam logic [3:0] GRP_WTHRU = 4'h3;

    localparam logic [3:0] SUB_LOAD  = 4'h1;
    localparam logic [3:0] SUB_CLEAR = 4'h2;
    localparam logic [3:0] SUB_POWER = 4'h3;
    localparam logic [3:0] SUB_LIN   = 4'h5;

    typedef enum logic [2:0] {
        K_NONE,
        K_WRITE,
        K_WTHRU,
        K_LOAD,
        K_CLEAR,
        K_POWER,
        K_LIN
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e           kind;
        logic [MASK_W-1:0]   chan_mask;
        logic [DATA_W-1:0]   data;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic valid, input logic [WORD_W-1:0] w);
        cmd_t c;
        c.kind      = K_NONE;
        c.chan_mask = '0;
        c.data      = w[DATA_W-1:0];
        if (valid) begin
            case (w[23:20])
                GRP_WRITE: begin
                    c.kind      = K_WRITE;
                    c.chan_mask = w[19:16];
                end
                GRP_WTHRU: begin
                    c.kind      = K_WTHRU;
                    c.chan_mask = w[19:16];
                end
                GRP_MISC: begin
                    case (w[19:16])
                        SUB_LOAD: begin
                            c.kind      = K_LOAD;
                            c.chan_mask = w[MASK_LO +: MASK_W];
                        end
                        SUB_CLEAR: c.kind = K_CLEAR;
                        SUB_POWER: begin
                            c.kind      = K_POWER;
                            c.chan_mask = w[MASK_LO +: MASK_W];
                        end
                        SUB_LIN:   c.kind = K_LIN;
                        default:   c.kind = K_NONE;
                    endcase
                end
                default: c.kind = K_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dacc_decode.sv
module dacc_decode
    import dacc_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    always_comb cmd = decode_cmd(valid, word);
endmodule

// File: rtl/dacc_sync.sv
module dacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic active
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], async_n};
    end

    assign active = ~q[STAGES-1];
endmodule

// File: rtl/dacc_channel.sv
module dacc_channel #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              wipe,
    input  logic              midscale_sel,
    input  logic              in_we,
    input  logic              dac_we_data,
    input  logic              dac_copy,
    input  logic              pd_we,
    input  logic              pd_val,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] dac_q,
    output logic              off_q
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] in_next;

    always_comb in_next = in_we ? code_in : in_q;

    always_ff @(posedge clk) begin
        if (wipe) begin
            in_q  <= '0;
            dac_q <= midscale_sel ? MID : '0;
            off_q <= 1'b0;
        end else begin
            in_q <= in_next;
            if (dac_we_data)   dac_q <= code_in;
            else if (dac_copy) dac_q <= in_next;
            if (pd_we)         off_q <= pd_val;
        end
    end
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
    import dacc_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CODE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [23:0]              cmd_word,
    input  logic                     load_n,
    input  logic                     midscale_sel,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        chan_off,
    output logic                     ready_en,
    output logic                     lin_cal,
    output logic                     ref_off
);
    cmd_t              cmd;
    logic              load_now;
    logic              wipe;
    logic [CODE_W-1:0] code;

    dacc_decode u_dec (.valid(cmd_valid), .word(cmd_word), .cmd(cmd));

    dacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_n(load_n), .active(load_now)
    );

    assign wipe = rst | (cmd.kind == K_CLEAR);
    assign code = cmd.data[DATA_W-1 -: CODE_W];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = cmd.chan_mask[i];
        dacc_channel #(.CODE_W(CODE_W)) u_ch (
            .clk         (clk),
            .wipe        (wipe),
            .midscale_sel(midscale_sel),
            .in_we       (sel && (cmd.kind == K_WRITE || cmd.kind == K_WTHRU)),
            .dac_we_data (sel && cmd.kind == K_WTHRU),
            .dac_copy    (load_now || (sel && cmd.kind == K_LOAD)),
            .pd_we       (cmd.kind == K_POWER),
            .pd_val      (sel),
            .code_in     (code),
            .dac_q       (dac_code[i*CODE_W +: CODE_W]),
            .off_q       (chan_off[i])
        );
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            ready_en <= 1'b1;
            lin_cal  <= 1'b0;
        end else begin
            if (cmd.kind == K_POWER) ready_en <= cmd.data[BIT_READY];
            if (cmd.kind == K_LIN)   lin_cal  <= cmd.data[BIT_LIN];
        end
    end

    assign ref_off = &chan_off;
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic [23:0]              cmd_word,
    input logic                     load_now,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        chan_off,
    input logic                     ready_en,
    input logic                     lin_cal,
    input logic                     ref_off
);
    logic [7:0] op;
    assign op = cmd_word[23:16];

    AST_RESET_POWERED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_off == '0 && ready_en && !lin_cal)); // R1

    AST_WRITE_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op[7:4] == 4'h1 && !load_now) |=> $stable(dac_code)); // R2

    AST_WTHRU_CH0: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op[7:4] == 4'h3 && op[0])
        |=> dac_code[CODE_W-1:0] == $past(cmd_word[15 -: CODE_W])); // R3

    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 8'h02) |=> (chan_off == '0 && ready_en && !lin_cal && !ref_off)); // R5

    AST_POWER_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 8'h03 && !load_now) |=> $stable(dac_code)); // R6

    AST_REF_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 8'h03 && (&cmd_word[8 +: NUM_CH])) |=> ref_off); // R7

    AST_REF_SOME_ON: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 8'h03 && !(&cmd_word[8 +: NUM_CH])) |=> !ref_off); // R7

    AST_LIN_BIT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 8'h05) |=> lin_cal == $past(cmd_word[8])); // R8

    AST_NOP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 8'h00 && !load_now)
        |=> ($stable(dac_code) && $stable(chan_off) && $stable(lin_cal) && $stable(ready_en))); // R9
endmodule

bind dac_bank_ctrl dacc_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word),
    .load_now (load_now),
    .dac_code (dac_code),
    .chan_off (chan_off),
    .ready_en (ready_en),
    .lin_cal  (lin_cal),
    .ref_off  (ref_off)
);

// File: tb/dac_bank_ctrl_test.sv
module dac_bank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic        load_n = 1'b1;
    logic        midscale_sel = 1'b0;

    logic [63:0] dac_big;
    logic [3:0]  off_big;
    logic        rdy_big, lin_big, ref_big;
    logic [23:0] dac_small;
    logic [1:0]  off_small;
    logic        rdy_small, lin_small, ref_small;

    always #4 clk = ~clk;

    dac_bank_ctrl #(.NUM_CH(4), .CODE_W(16)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .load_n(load_n), .midscale_sel(midscale_sel), .dac_code(dac_big),
        .chan_off(off_big), .ready_en(rdy_big), .lin_cal(lin_big), .ref_off(ref_big)
    );

    dac_bank_ctrl #(.NUM_CH(2), .CODE_W(12)) uut_small (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .load_n(load_n), .midscale_sel(midscale_sel), .dac_code(dac_small),
        .chan_off(off_small), .ready_en(rdy_small), .lin_cal(lin_small), .ref_off(ref_small)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_in [4];
    logic [15:0] m_dac[4];
    logic [11:0] s_in [2];
    logic [11:0] s_dac[2];
    logic [3:0]  m_off;
    logic        m_rdy, m_lin;
    bit          hw;

    function automatic logic [15:0] val(int a);
        return 16'((a * 11213 + 403) & 32'hFFFF);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_in[i]  = '0;
            m_dac[i] = midscale_sel ? 16'h8000 : 16'h0000;
        end
        for (int i = 0; i < 2; i++) begin
            s_in[i]  = '0;
            s_dac[i] = midscale_sel ? 12'h800 : 12'h000;
        end
        m_off = '0;
        m_rdy = 1'b1;
        m_lin = 1'b0;
    endtask

    task automatic model_copy_all();
        for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
        for (int i = 0; i < 2; i++) s_dac[i] = s_in[i];
    endtask

    task automatic model_cmd(logic [23:0] w);
        logic [7:0]  op;
        logic [15:0] d;
        op = w[23:16];
        d  = w[15:0];
        if (op[7:4] == 4'h1 || op[7:4] == 4'h3) begin
            for (int i = 0; i < 4; i++) if (op[i]) begin
                m_in[i] = d;
                if (op[7:4] == 4'h3) m_dac[i] = d;
            end
            for (int i = 0; i < 2; i++) if (op[i]) begin
                s_in[i] = d[15:4];
                if (op[7:4] == 4'h3) s_dac[i] = d[15:4];
            end
        end else begin
            case (op)
                8'h01: begin
                    for (int i = 0; i < 4; i++) if (d[8+i]) m_dac[i] = m_in[i];
                    for (int i = 0; i < 2; i++) if (d[8+i]) s_dac[i] = s_in[i];
                end
                8'h02: model_reset();
                8'h03: begin
                    m_off = d[11:8];
                    m_rdy = d[7];
                end
                8'h05: m_lin = d[8];
                default: ;
            endcase
        end
        if (hw) model_copy_all();
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 4; i++) chk(req, $sformatf("big dac%0d", i), 32'(dac_big[i*16 +: 16]), 32'(m_dac[i]));
        chk(req, "big chan_off", 32'(off_big), 32'(m_off));
        chk(req, "big ready_en", 32'(rdy_big), 32'(m_rdy));
        chk(req, "big lin_cal", 32'(lin_big), 32'(m_lin));
        chk(req, "big ref_off R7", 32'(ref_big), 32'(&m_off));
        for (int i = 0; i < 2; i++) chk(req, $sformatf("small dac%0d R11", i), 32'(dac_small[i*12 +: 12]), 32'(s_dac[i]));
        chk(req, "small chan_off R11", 32'(off_small), 32'(m_off[1:0]));
        chk(req, "small ref_off R11", 32'(ref_small), 32'(&m_off[1:0]));
        chk(req, "small ready_en", 32'(rdy_small), 32'(m_rdy));
        chk(req, "small lin_cal", 32'(lin_small), 32'(m_lin));
    endtask

    task automatic send(logic [23:0] w, string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_cmd(w);
        check_all(req);
    endtask

    task automatic do_reset(logic mid);
        @(negedge clk);
        midscale_sel = mid;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        hw = 0;
        model_reset();
        // R1: reset to zero, then to midscale
        do_reset(1'b0);
        do_reset(1'b1);
        do_reset(1'b0);

        // R2 / R11: staged writes for every mask; outputs must not move
        for (int m = 0; m < 16; m++) send({4'h1, 4'(m), val(m)}, "R2");

        // R4: masked transfer sweep with distinct per-channel staging values
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 4; c++) send({4'h1, 4'(1 << c), val(100 + m * 4 + c)}, "R2");
            send({8'h01, 4'h0, 4'(m), 8'hA5}, "R4");
        end

        // R3 / R11: writethrough sweep, low nibble nonzero
        for (int m = 0; m < 16; m++) send({4'h3, 4'(m), val(300 + m) | 16'h000F}, "R3");

        // R6 / R7: power-down sweep, codes kept, READY enable from bit 7
        for (int m = 0; m < 16; m++) send({8'h03, 4'h0, 4'(m), 1'(m), 7'h3C}, "R6");
        send({8'h03, 16'h0080}, "R6");

        // R8: calibration bit set and clear
        send({8'h05, 16'h0100}, "R8");
        send({8'h05, 16'hFEFF}, "R8");
        send({8'h05, 16'hFFFF}, "R8");

        // R9: no-op, undefined opcodes, and a write with valid low
        send({8'h00, 16'hFFFF}, "R9");
        send({8'h04, 16'h0F80}, "R9");
        send({8'h06, 16'h0F00}, "R9");
        send({8'h0F, 16'h0F00}, "R9");
        send({8'h2F, 16'h1234}, "R9");
        send({8'h7F, 16'h4321}, "R9");
        send({8'hFF, 16'hFFFF}, "R9");
        @(negedge clk);
        cmd_word = {8'h3F, 16'hDEAD};
        @(negedge clk);
        check_all("R9");

        // R5: clear restores midscale, then zero
        send({8'h03, 16'h0500}, "R6");
        midscale_sel = 1'b1;
        send({8'h02, 16'hFFFF}, "R5");
        send({8'h3F, 16'h4444}, "R3");
        midscale_sel = 1'b0;
        send({8'h02, 16'h0000}, "R5");

        // R10: hardware load through the synchronizer
        for (int c = 0; c < 4; c++) send({4'h1, 4'(1 << c), val(500 + c)}, "R2");
        @(negedge clk);
        load_n = 1'b0;
        @(negedge clk);
        check_all("R10");
        @(negedge clk);
        check_all("R10");
        @(negedge clk);
        model_copy_all();
        check_all("R10");
        hw = 1;
        send({8'h12, 16'hBEEF}, "R10");
        send({8'h19, 16'h7A51}, "R10");
        @(negedge clk);
        load_n = 1'b1;
        repeat (3) @(negedge clk);
        hw = 0;
        check_all("R10");
        send({8'h1F, 16'h0C0C}, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule